// File: doc/BRIEF.md
# DDR Single-Bank Write Sequencer with Auto Precharge

The block turns one host write request into the command and strobe timeline that writes one four-beat burst to a DDR SDRAM bank. A request carries a bank, a row, a column, four data words and an optional extra delay, counted in cycles, between opening the row and writing it. The block opens the row with an ACTIVE command. It then issues a WRITE that has the auto-precharge address bit set, so the device closes the row by itself and no separate PRECHARGE command is ever sent.

Around the WRITE the block drives the strobe enable through a preamble cycle, two data cycles and a postamble cycle. Each data cycle carries one word for the rising half and one word for the falling half, and the data mask stays low. The bank may close only once two conditions hold: the minimum row-active time has passed since ACTIVE, and write recovery has passed since the last data beat. After that the precharge time must also run out before `req_ready` lets the next ACTIVE through. If a request would keep the row open past the maximum row-active time, it is turned away with a one-cycle error pulse. All timings are parameters given in clock cycles.

Top module: `ddr_wap_seq`

## Requirements
- R1: After reset the command bus shows NOP (`ddr_cmd` = 4'b0111, encoded {cs_n, ras_n, cas_n, we_n}), all strobe and data enables are low, `req_err` is low and `req_ready` is high.
- R2: When a request is accepted (`req_valid` and `req_ready` both high at a clock edge), the next cycle shows ACTIVE (`ddr_cmd` = 4'b0011) with `ddr_ba` = the bank and `ddr_addr` = the row. `req_ready` stays low from that cycle until the bank may reopen.
- R3: The WRITE command (`ddr_cmd` = 4'b0100) appears exactly T_RCD + `req_delay` cycles after ACTIVE. It carries the same bank, has the column in the low address bits and has address bit AP_BIT (10) high.
- R4: In the WRITE cycle `dqs_oe` is high while `dqs_run` and `dq_oe` are low. This is the strobe preamble.
- R5: The two cycles after WRITE carry data with `dqs_run` and `dq_oe` high. The first cycle drives words 0 and 1 on `dq_rise`/`dq_fall`, and the second drives words 2 and 3. Word i is `req_wdata[8*i +: 8]`. `dm_rise` and `dm_fall` are low in both cycles.
- R6: The cycle after the last data cycle is a postamble: `dqs_oe` is high, while `dqs_run` and `dq_oe` are low. After it all enables are low.
- R7: With a request waiting, the next ACTIVE follows the previous one by exactly max(T_RAS_MIN, T_RCD + `req_delay` + 3 + T_WR) + T_RP cycles.
- R8: If T_RCD + `req_delay` + 3 + T_WR exceeds T_RAS_MAX, the request is consumed without any command or strobe. `req_err` is high for the one cycle after acceptance, and `req_ready` stays high.
- R9: While `req_ready` is low, `req_valid` and the request fields have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_bank | input | BA_W (2) | Target bank |
| req_row | input | ROW_W (13) | Row to open |
| req_col | input | COL_W (10) | Starting column of the burst |
| req_wdata | input | 4*DQ_W (32) | Four burst words, word 0 in the low bits |
| req_delay | input | DLY_W (16) | Extra cycles between ACTIVE and WRITE |
| req_err | output | 1 | One-cycle pulse: request rejected for excess row-open time |
| ddr_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ddr_ba | output | BA_W (2) | Bank address |
| ddr_addr | output | ROW_W (13) | Row or column address |
| dqs_oe | output | 1 | Strobe output enable (preamble, data, postamble) |
| dqs_run | output | 1 | Strobe toggles this cycle (data cycles) |
| dq_oe | output | 1 | Data output enable |
| dq_rise | output | DQ_W (8) | Word for the rising half of the cycle |
| dq_fall | output | DQ_W (8) | Word for the falling half of the cycle |
| dm_rise | output | 1 | Mask for the rising-half word |
| dm_fall | output | 1 | Mask for the falling-half word |

## Verification
Once a request is accepted at an edge, its results fall in fixed cycles. ACTIVE or the error pulse comes one cycle later. WRITE with the preamble comes T_RCD + delay cycles after ACTIVE, the two data cycles follow it, and the postamble comes after them. The earliest next acceptance is max(T_RAS_MIN, write end + T_WR) + T_RP − 1 cycles after ACTIVE. The driver counts cycles from the acceptance edge and queues each expected output pattern tagged with its absolute cycle. The monitor samples on the falling edge and pops one entry for every non-idle cycle it sees. It flags a cycle mismatch, a missing entry or any unexpected non-idle cycle, and the driver also checks that each acceptance lands on the predicted cycle.

// File: rtl/ddr_wap_seq.sv
module ddr_wap_seq #(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int DQ_W      = 8,
  parameter int DLY_W     = 16,
  parameter int T_RCD     = 3,
  parameter int T_RAS_MIN = 8,
  parameter int T_RAS_MAX = 14000,
  parameter int T_WR      = 3,
  parameter int T_RP      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [BA_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [4*DQ_W-1:0]   req_wdata,
  input  logic [DLY_W-1:0]    req_delay,
  output logic                req_err,
  output logic [3:0]          ddr_cmd,
  output logic [BA_W-1:0]     ddr_ba,
  output logic [ROW_W-1:0]    ddr_addr,
  output logic                dqs_oe,
  output logic                dqs_run,
  output logic                dq_oe,
  output logic [DQ_W-1:0]     dq_rise,
  output logic [DQ_W-1:0]     dq_fall,
  output logic                dm_rise,
  output logic                dm_fall
);
  localparam int ADDR_W = ROW_W;
  localparam int CNT_W  = $clog2(T_RAS_MAX + T_RP + 1) + 1;
  localparam int OW     = ((DLY_W > CNT_W) ? DLY_W : CNT_W) + 2;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_WR  = 4'b0100;

  logic              busy;
  logic [CNT_W-1:0]  t, g_q, last_q;
  logic [BA_W-1:0]   bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [4*DQ_W-1:0] data_q;
  logic              err_q;

  logic [OW-1:0] gap, wr_end, open_cyc;
  logic          too_long, accept;

  assign gap      = OW'(T_RCD) + OW'(req_delay);
  assign wr_end   = gap + OW'(3 + T_WR);
  assign too_long = wr_end > OW'(T_RAS_MAX);
  assign open_cyc = (wr_end > OW'(T_RAS_MIN)) ? wr_end : OW'(T_RAS_MIN);

  assign req_ready = !busy || (t == last_q);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      t      <= '0;
      g_q    <= '0;
      last_q <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && too_long;
      if (accept && !too_long) begin
        busy   <= 1'b1;
        t      <= '0;
        g_q    <= CNT_W'(gap);
        last_q <= CNT_W'(open_cyc + OW'(T_RP - 1));
        bank_q <= req_bank;
        row_q  <= req_row;
        col_q  <= req_col;
        data_q <= req_wdata;
      end else if (busy) begin
        if (t == last_q) busy <= 1'b0;
        else             t    <= t + CNT_W'(1);
      end
    end
  end

  logic ph_act, ph_wr, ph_d0, ph_d1, ph_post;
  assign ph_act  = busy && (t == '0);
  assign ph_wr   = busy && (t == g_q);
  assign ph_d0   = busy && (t == g_q + CNT_W'(1));
  assign ph_d1   = busy && (t == g_q + CNT_W'(2));
  assign ph_post = busy && (t == g_q + CNT_W'(3));

  logic [ADDR_W-1:0] wr_addr;
  assign wr_addr = ADDR_W'(col_q) | (ADDR_W'(1) << AP_BIT);

  assign req_err  = err_q;
  assign ddr_cmd  = ph_act ? CMD_ACT : ph_wr ? CMD_WR : CMD_NOP;
  assign ddr_ba   = (ph_act || ph_wr) ? bank_q : '0;
  assign ddr_addr = ph_act ? row_q : ph_wr ? wr_addr : '0;
  assign dqs_oe   = ph_wr || ph_d0 || ph_d1 || ph_post;
  assign dqs_run  = ph_d0 || ph_d1;
  assign dq_oe    = ph_d0 || ph_d1;
  assign dq_rise  = ph_d0 ? data_q[0*DQ_W +: DQ_W] : ph_d1 ? data_q[2*DQ_W +: DQ_W] : '0;
  assign dq_fall  = ph_d0 ? data_q[1*DQ_W +: DQ_W] : ph_d1 ? data_q[3*DQ_W +: DQ_W] : '0;
  assign dm_rise  = 1'b0;
  assign dm_fall  = 1'b0;
endmodule

module ddr_wap_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int AP_BIT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_err,
  input logic [3:0]       ddr_cmd,
  input logic [ROW_W-1:0] ddr_addr,
  input logic             dqs_oe,
  input logic             dqs_run,
  input logic             dq_oe,
  input logic             dm_rise,
  input logic             dm_fall
);
  p_act_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ddr_cmd == 4'b0011 || req_err));
  p_busy_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_cmd == 4'b0011) |-> !req_ready);
  p_write_ap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_cmd == 4'b0100) |-> ddr_addr[AP_BIT]);
  p_preamble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_cmd == 4'b0100) |-> (dqs_oe && !dqs_run && !dq_oe));
  p_data_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_cmd == 4'b0100) |=> (dq_oe && dqs_run));
  p_mask_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!dm_rise && !dm_fall));
  p_postamble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_run) |-> (dqs_oe && !dq_oe));
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (ddr_cmd == 4'b0111 && !dqs_oe && req_ready));
endmodule

bind ddr_wap_seq ddr_wap_seq_chk #(.ROW_W(ROW_W), .AP_BIT(AP_BIT)) chk_i (.*);

// File: tb/ddr_wap_seq_tb_top.sv
module ddr_wap_seq_tb_top;
  localparam int RCD = 3, RASMIN = 12, RASMAX = 40, WR = 3, RP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready, req_err;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [31:0] req_wdata = '0;
  logic [15:0] req_delay = '0;
  logic [3:0]  ddr_cmd;
  logic [1:0]  ddr_ba;
  logic [12:0] ddr_addr;
  logic        dqs_oe, dqs_run, dq_oe, dm_rise, dm_fall;
  logic [7:0]  dq_rise, dq_fall;

  ddr_wap_seq #(.T_RCD(RCD), .T_RAS_MIN(RASMIN), .T_RAS_MAX(RASMAX),
                .T_WR(WR), .T_RP(RP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_delay(req_delay), .req_err(req_err),
    .ddr_cmd(ddr_cmd), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr),
    .dqs_oe(dqs_oe), .dqs_run(dqs_run), .dq_oe(dq_oe),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall));

  typedef struct {
    int          cyc;
    logic [40:0] vec;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int total = 0, fails = 0;
  int ready_at = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [40:0] pack(logic [3:0] c, logic [1:0] b, logic [12:0] a,
      logic so, logic sr, logic de, logic [7:0] r, logic [7:0] f, logic mr, logic mf, logic e);
    return {c, b, a, so, sr, de, r, f, mr, mf, e};
  endfunction

  function automatic logic [40:0] obs();
    return pack(ddr_cmd, ddr_ba, ddr_addr, dqs_oe, dqs_run, dq_oe,
                dq_rise, dq_fall, dm_rise, dm_fall, req_err);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic push(int c, logic [40:0] v, string tag);
    exp_t e;
    e.cyc = c; e.vec = v; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        while (q.size() > 0 && q[0].cyc < cyc) begin
          check(1'b0, {q[0].tag, " missing"}, 64'(cyc), 64'(q[0].cyc));
          void'(q.pop_front());
        end
        if (ddr_cmd != 4'b0111 || dqs_oe || dq_oe || req_err) begin
          if (q.size() == 0) check(1'b0, "R9 unexpected output", 64'(obs()), 64'(0));
          else begin
            exp_t e;
            e = q.pop_front();
            check(e.cyc == cyc && e.vec == obs(), e.tag, {23'd0, obs()}, {23'd0, e.vec});
          end
        end
      end
    end
  end

  task automatic send(logic [1:0] b, logic [12:0] r, logic [9:0] c, logic [31:0] d, int dly);
    int c0, k, g, we, p;
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_wdata = d;
    req_delay = 16'(dly);
    c0 = cyc;
    while (!req_ready) @(negedge clk);
    k = cyc;
    check(k == ((c0 > ready_at) ? c0 : ready_at), "R7 accept cycle", 64'(k), 64'(ready_at));
    @(posedge clk);
    #1 req_valid = 1'b0;
    g  = RCD + dly;
    we = g + 3 + WR;
    if (we > RASMAX) begin
      push(k + 1, pack(4'b0111, 2'd0, 13'd0, 0, 0, 0, 8'd0, 8'd0, 0, 0, 1), "R8 reject");
      ready_at = k + 1;
    end else begin
      p = (we > RASMIN) ? we : RASMIN;
      push(k + 1, pack(4'b0011, b, r, 0, 0, 0, 8'd0, 8'd0, 0, 0, 0), "R2 activate");
      push(k + 1 + g, pack(4'b0100, b, 13'(c) | 13'h400, 1, 0, 0, 8'd0, 8'd0, 0, 0, 0),
           "R3 R4 write with preamble");
      push(k + 2 + g, pack(4'b0111, 2'd0, 13'd0, 1, 1, 1, d[7:0], d[15:8], 0, 0, 0), "R5 beats 0-1");
      push(k + 3 + g, pack(4'b0111, 2'd0, 13'd0, 1, 1, 1, d[23:16], d[31:24], 0, 0, 0), "R5 beats 2-3");
      push(k + 4 + g, pack(4'b0111, 2'd0, 13'd0, 1, 0, 0, 8'd0, 8'd0, 0, 0, 0), "R6 postamble");
      ready_at = k + p + RP;
    end
  endtask

  task automatic poke(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_bank = 2'd2; req_row = 13'h1ABC; req_col = 10'h155;
      req_wdata = 32'hDEADBEEF; req_delay = 16'd0;
      check(!req_ready, "R9 ready low while busy", 64'(req_ready), 64'(0));
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(obs() == pack(4'b0111, 2'd0, 13'd0, 0, 0, 0, 8'd0, 8'd0, 0, 0, 0) && req_ready,
          "R1 reset idle", {23'd0, obs()}, 64'(0));
    rst_n = 1'b1;
    send(2'd1, 13'h0123, 10'h004, 32'h44332211, 0);
    send(2'd2, 13'h1F00, 10'h3F8, 32'hA5B6C7D8, 5);
    poke(3);
    send(2'd0, 13'h0001, 10'h002, 32'h0F1E2D3C, 0);
    send(2'd3, 13'h1FFF, 10'h3FF, 32'h12345678, 32);
    send(2'd3, 13'h1FFF, 10'h3FF, 32'h87654321, 31);
    send(2'd1, 13'h0AAA, 10'h001, 32'hFFFF0000, 2);
    repeat (60) @(negedge clk);
    check(q.size() == 0, "R2 all queued outputs seen", 64'(q.size()), 64'(0));
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", 64'(cyc), 64'(0));
    finish_up();
  end
endmodule